// File: doc/BRIEF.md
# Parallel EEPROM Page-Write Engine with Completion Polling

This block is a clocked model of the write side of a byte-wide parallel EEPROM. It sees an already-synchronised chip select, write enable and output enable, all active low, together with a 17-bit byte address and an 8-bit data bus. A write pulse moves one byte into a page buffer of 128 entries. Each accepted pulse restarts a load window. While the window is open, further bytes of the same page can join the burst. When the window closes without a new write, a programming phase of fixed length begins. At its end every loaded byte is copied into the backing array in one step.

While the engine is busy, software can poll for completion by reading back the last byte it wrote. That byte comes back with its top bit inverted until the commit has taken place. All other reads return the array contents. The backing array holds `NUM_PAGES` pages. Address bits above the array size alias onto it, so with the default of 8 pages the array index is the low 10 address bits. The load window and the programming length are parameters counted in clock cycles.

Top module: `eep_page_writer`

## Requirements
- R1: After reset `busy` is low and every array byte is 0x00, so any read returns 0x00.
- R2: `dataOutEn` is high exactly when `csN` is low, `oeN` is low and `weN` is high. In that case `dataOut` shows the byte selected by `addr`. At all other times `dataOut` is 0x00.
- R3: A write pulse is accepted only if `oeN` is high in the first sampled cycle where `csN` and `weN` are both low. A pulse with `oeN` low never raises `busy`. If `oeN` is low in the cycle where the pulse ends, the byte is discarded.
- R4: The byte address is taken from the first sampled cycle where `csN` and `weN` are both low. The data is taken from the last sampled cycle before either of them rises.
- R5: An accepted pulse start restarts the load window from zero. With no further accepted start, programming begins `LOAD_CYCLES` clock edges after the last accepted start.
- R6: Programming lasts `PROG_CYCLES` clock edges. All loaded bytes become visible together at its end, on the same edge where `busy` falls. With no further writes, that edge is `LOAD_CYCLES+PROG_CYCLES` edges after the last accepted start.
- R7: The page of a burst is `addr[16:7]` of its first accepted start. A later start during loading with a different page is ignored: no byte is loaded and the window is not restarted.
- R8: Write pulses that start during programming are ignored and do not lengthen the busy period.
- R9: Bytes of the page that were not loaded in a burst keep their earlier array values after the commit.
- R10: While `busy` is high and a byte of the current burst has been loaded, a read at the exact 17-bit address of the last loaded byte returns that byte with bit 7 inverted and bits 6..0 unchanged. Other reads return the array contents from before the commit. Once `busy` is low, the true byte is returned.
- R11: `busy` is high from the edge that accepts the first start of a burst through to the commit edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| csN | input | 1 | Chip select, active low, sampled |
| weN | input | 1 | Write enable, active low, sampled |
| oeN | input | 1 | Output enable, active low, sampled |
| addr | input | 17 | Byte address |
| dataIn | input | 8 | Write data |
| dataOut | output | 8 | Read data, 0x00 when not driven |
| dataOutEn | output | 1 | High while the read data is driven |
| busy | output | 1 | High during loading and programming |

## Verification
The hardest states to reach from the ports are those defined by the pulse's sampled cycles. The address is fixed at the pulse's first cycle and the data at its last. Output enable can also drop inside a pulse that was already accepted. A dedicated pulse task changes the address and data, or drops output enable, between the start cycle and the end cycle. It then reads the affected locations back after the commit.

The retrigger window and the ignored writes during programming are timed in clock edges from the accepted start. The bench then counts cycles until `busy` falls and compares the count with `LOAD_CYCLES+PROG_CYCLES`.

// File: rtl/eep_pkg.sv
package eep_pkg;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_LOAD = 2'd1,
    PH_PROG = 2'd2
  } phase_t;

  // strobes from control to datapath
  typedef struct packed {
    logic latchAddr;   // accepted pulse start: capture byte address
    logic latchPage;   // first start of a burst: capture page tag
    logic sampleData;  // pulse active this cycle: track data bus
    logic loadByte;    // pulse ended cleanly: write byte into page buffer
    logic commit;      // last programming cycle: copy buffer into array
    logic busy;        // loading or programming
  } strobe_t;

endpackage

// File: rtl/eep_write_ctrl.sv
module eep_write_ctrl
  import eep_pkg::*;
#(
  parameter int LOAD_CYCLES = 40,
  parameter int PROG_CYCLES = 60
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    csN,
  input  logic    weN,
  input  logic    oeN,
  input  logic    pageMatch,
  output strobe_t stb
);

  localparam int LW = $clog2(LOAD_CYCLES);
  localparam int PW = $clog2(PROG_CYCLES);

  phase_t        phase;
  logic [LW-1:0] loadCnt;
  logic [PW-1:0] progCnt;
  logic          prevActive;
  logic          pulseOk;

  logic curActive, startEdge, endEdge, startOk, lastLoad, lastProg;

  always_comb begin
    curActive = !csN && !weN && oeN;
    startEdge = curActive && !prevActive;
    endEdge   = prevActive && !curActive;
    startOk   = startEdge &&
                ((phase == PH_IDLE) || ((phase == PH_LOAD) && pageMatch));
    lastLoad  = (loadCnt == LW'(LOAD_CYCLES - 1));
    lastProg  = (progCnt == PW'(PROG_CYCLES - 1));

    stb.latchAddr  = startOk;
    stb.latchPage  = startOk && (phase == PH_IDLE);
    stb.sampleData = curActive;
    stb.loadByte   = endEdge && pulseOk && (phase == PH_LOAD) && oeN;
    stb.commit     = (phase == PH_PROG) && lastProg;
    stb.busy       = (phase != PH_IDLE);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase      <= PH_IDLE;
      loadCnt    <= '0;
      progCnt    <= '0;
      prevActive <= 1'b0;
      pulseOk    <= 1'b0;
    end else begin
      prevActive <= curActive;
      if (startEdge)    pulseOk <= startOk;
      else if (endEdge) pulseOk <= 1'b0;

      unique case (phase)
        PH_IDLE: begin
          if (startOk) begin
            phase   <= PH_LOAD;
            loadCnt <= '0;
          end
        end
        PH_LOAD: begin
          if (startOk) begin
            loadCnt <= '0;
          end else if (lastLoad) begin
            phase   <= PH_PROG;
            progCnt <= '0;
          end else begin
            loadCnt <= loadCnt + 1'b1;
          end
        end
        PH_PROG: begin
          if (lastProg) phase <= PH_IDLE;
          else          progCnt <= progCnt + 1'b1;
        end
        default: phase <= PH_IDLE;
      endcase
    end
  end

  // a byte is only loaded by a pulse whose selects were low the cycle before
  assert_load_after_pulse_R3: assert property (@(posedge clk) disable iff (!rstN)
    stb.loadByte |-> $past(!csN && !weN));

  // an accepted start leaves the engine busy
  assert_busy_after_start_R11: assert property (@(posedge clk) disable iff (!rstN)
    stb.latchAddr |=> stb.busy);

  // the commit cycle is the last busy cycle
  assert_commit_ends_busy_R6: assert property (@(posedge clk) disable iff (!rstN)
    stb.commit |=> !stb.busy);

  // busy only falls through a commit
  assert_busy_fall_by_commit_R6: assert property (@(posedge clk) disable iff (!rstN)
    $fell(stb.busy) |-> $past(stb.commit));

endmodule

// File: rtl/eep_page_data.sv
module eep_page_data
  import eep_pkg::*;
#(
  parameter int ADDR_W    = 17,
  parameter int DATA_W    = 8,
  parameter int PAGE_BITS = 7,
  parameter int NUM_PAGES = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           stb,
  input  logic              csN,
  input  logic              weN,
  input  logic              oeN,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] dataIn,
  output logic              pageMatch,
  output logic [DATA_W-1:0] dataOut,
  output logic              dataOutEn
);

  localparam int PAGE_LEN = 1 << PAGE_BITS;
  localparam int SEL_W    = $clog2(NUM_PAGES);
  localparam int IDX_W    = SEL_W + PAGE_BITS;
  localparam int DEPTH    = NUM_PAGES * PAGE_LEN;
  localparam int TAG_W    = ADDR_W - PAGE_BITS;

  logic [DATA_W-1:0] mem     [DEPTH];
  logic [DATA_W-1:0] pageBuf [PAGE_LEN];
  logic [PAGE_LEN-1:0] valid;

  logic [ADDR_W-1:0] addrLatch;
  logic [TAG_W-1:0]  pageReg;
  logic [DATA_W-1:0] dataHold;
  logic [ADDR_W-1:0] lastAddr;
  logic [DATA_W-1:0] lastData;
  logic              lastValid;

  logic pollHit;

  assign pageMatch = (addr[ADDR_W-1:PAGE_BITS] == pageReg);

  // capture registers for the pulse in flight
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrLatch <= '0;
      pageReg   <= '0;
      dataHold  <= '0;
    end else begin
      if (stb.latchAddr)  addrLatch <= addr;
      if (stb.latchPage)  pageReg   <= addr[ADDR_W-1:PAGE_BITS];
      if (stb.sampleData) dataHold  <= dataIn;
    end
  end

  // page buffer, last-written tracking and backing array
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < DEPTH; i++)    mem[i]     <= '0;
      for (int i = 0; i < PAGE_LEN; i++) pageBuf[i] <= '0;
      valid     <= '0;
      lastAddr  <= '0;
      lastData  <= '0;
      lastValid <= 1'b0;
    end else begin
      if (stb.loadByte) begin
        pageBuf[addrLatch[PAGE_BITS-1:0]] <= dataHold;
        valid[addrLatch[PAGE_BITS-1:0]]   <= 1'b1;
        lastAddr  <= addrLatch;
        lastData  <= dataHold;
        lastValid <= 1'b1;
      end
      if (stb.commit) begin
        for (int i = 0; i < PAGE_LEN; i++) begin
          if (valid[i]) mem[{pageReg[SEL_W-1:0], PAGE_BITS'(i)}] <= pageBuf[i];
        end
        valid     <= '0;
        lastValid <= 1'b0;
      end
    end
  end

  // read port with completion polling on the last loaded byte
  always_comb begin
    dataOutEn = !csN && !oeN && weN;
    pollHit   = stb.busy && lastValid && (addr == lastAddr);
    if (!dataOutEn)
      dataOut = '0;
    else if (pollHit)
      dataOut = {~lastData[DATA_W-1], lastData[DATA_W-2:0]};
    else
      dataOut = mem[addr[IDX_W-1:0]];
  end

  // a loaded byte always belongs to the page that opened the burst
  assert_page_lock_R7: assert property (@(posedge clk) disable iff (!rstN)
    stb.loadByte |-> (addrLatch[ADDR_W-1:PAGE_BITS] == pageReg));

  // after the commit the array holds the last loaded byte
  assert_commit_stores_R6: assert property (@(posedge clk) disable iff (!rstN)
    (stb.commit && lastValid) |=> (mem[lastAddr[IDX_W-1:0]] == lastData));

endmodule

// File: rtl/eep_page_writer.sv
module eep_page_writer
  import eep_pkg::*;
#(
  parameter int ADDR_W      = 17,
  parameter int DATA_W      = 8,
  parameter int PAGE_BITS   = 7,
  parameter int NUM_PAGES   = 8,
  parameter int LOAD_CYCLES = 40,
  parameter int PROG_CYCLES = 60
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              csN,
  input  logic              weN,
  input  logic              oeN,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] dataIn,
  output logic [DATA_W-1:0] dataOut,
  output logic              dataOutEn,
  output logic              busy
);

  strobe_t stb;
  logic    pageMatch;

  eep_write_ctrl #(
    .LOAD_CYCLES(LOAD_CYCLES),
    .PROG_CYCLES(PROG_CYCLES)
  ) u_ctrl (
    .clk(clk),
    .rstN(rstN),
    .csN(csN),
    .weN(weN),
    .oeN(oeN),
    .pageMatch(pageMatch),
    .stb(stb)
  );

  eep_page_data #(
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W),
    .PAGE_BITS(PAGE_BITS),
    .NUM_PAGES(NUM_PAGES)
  ) u_data (
    .clk(clk),
    .rstN(rstN),
    .stb(stb),
    .csN(csN),
    .weN(weN),
    .oeN(oeN),
    .addr(addr),
    .dataIn(dataIn),
    .pageMatch(pageMatch),
    .dataOut(dataOut),
    .dataOutEn(dataOutEn)
  );

  assign busy = stb.busy;

endmodule

// File: tb/sim_eep_page_writer.sv
`timescale 1ns/1ps
module sim_eep_page_writer;

  localparam int L     = 40;
  localparam int P     = 60;
  localparam int NP    = 8;
  localparam int DEPTH = NP * 128;

  logic        clk = 1'b0;
  logic        rstN;
  logic        csN, weN, oeN;
  logic [16:0] addr;
  logic [7:0]  dataIn;
  logic [7:0]  dataOut;
  logic        dataOutEn;
  logic        busy;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;

  always #2.5 clk = ~clk;

  eep_page_writer #(
    .ADDR_W(17), .DATA_W(8), .PAGE_BITS(7), .NUM_PAGES(NP),
    .LOAD_CYCLES(L), .PROG_CYCLES(P)
  ) u0 (
    .clk(clk), .rstN(rstN), .csN(csN), .weN(weN), .oeN(oeN),
    .addr(addr), .dataIn(dataIn), .dataOut(dataOut),
    .dataOutEn(dataOutEn), .busy(busy)
  );

  // ---------------- behavioural reference ----------------
  int          mPhase;   // 0 idle, 1 loading, 2 programming
  int          mTimer, mProg;
  bit          mPrevAct, mPulseOk, mLastValid;
  int          mPage;
  logic [16:0] mAddrLat, mLastAddr;
  logic [7:0]  mHold, mLastData;
  logic [7:0]  mMem [DEPTH];
  logic [7:0]  mBuf [int];

  always @(posedge clk) begin
    if (!rstN) begin
      mPhase = 0; mTimer = 0; mProg = 0;
      mPrevAct = 0; mPulseOk = 0; mLastValid = 0;
      mPage = 0; mAddrLat = '0; mLastAddr = '0; mHold = '0; mLastData = '0;
      for (int i = 0; i < DEPTH; i++) mMem[i] = 8'h00;
      mBuf.delete();
    end else begin
      bit act, st, en, ok;
      act = !csN && !weN && oeN;
      st  = act && !mPrevAct;
      en  = mPrevAct && !act;
      ok  = st && (mPhase == 0 || (mPhase == 1 && int'(addr[16:7]) == mPage));
      if (en && mPulseOk && mPhase == 1 && oeN) begin
        mBuf[int'(mAddrLat[6:0])] = mHold;
        mLastAddr  = mAddrLat;
        mLastData  = mHold;
        mLastValid = 1;
      end
      if (st) mPulseOk = ok; else if (en) mPulseOk = 0;
      if (ok) begin
        if (mPhase == 0) mPage = int'(addr[16:7]);
        mAddrLat = addr;
      end
      if (act) mHold = dataIn;
      case (mPhase)
        0: if (ok) begin mPhase = 1; mTimer = 0; end
        1: begin
          if (ok) mTimer = 0;
          else if (mTimer == L - 1) begin mPhase = 2; mProg = 0; end
          else mTimer++;
        end
        default: begin
          if (mProg == P - 1) begin
            foreach (mBuf[k]) mMem[(mPage % NP) * 128 + k] = mBuf[k];
            mBuf.delete();
            mLastValid = 0;
            mPhase = 0;
          end else mProg++;
        end
      endcase
      mPrevAct = act;
    end
  end

  // per-clock comparison away from the active edge
  always @(negedge clk) begin
    if (rstN) begin
      logic       expEn;
      logic [7:0] expD;
      expEn = !csN && !oeN && weN;
      if (!expEn) expD = 8'h00;
      else if (mPhase != 0 && mLastValid && addr == mLastAddr)
        expD = {~mLastData[7], mLastData[6:0]};
      else expD = mMem[int'(addr) % DEPTH];
      checks += 3;
      if (busy !== (mPhase != 0)) begin
        fails++;
        $display("FAIL R11 busy actual=%0b expected=%0b t=%0t", busy, (mPhase != 0), $time);
      end
      if (dataOutEn !== expEn) begin
        fails++;
        $display("FAIL R2 dataOutEn actual=%0b expected=%0b t=%0t", dataOutEn, expEn, $time);
      end
      if (dataOut !== expD) begin
        fails++;
        $display("FAIL R10 dataOut actual=%0h expected=%0h t=%0t", dataOut, expD, $time);
      end
    end
  end

  // ---------------- watchdog ----------------
  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  // ---------------- helpers ----------------
  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // one read cycle: drives the read, checks, releases after one edge
  task automatic read_chk(input string tag, input logic [16:0] a, input int exp);
    addr = a; csN = 0; oeN = 0; weN = 1;
    #1;
    chk(tag, dataOut, exp);
    chk("R2 enable during read", dataOutEn, 1);
    tick();
    csN = 1; oeN = 1;
  endtask

  // six edges; start accepted on the third, returns three edges after it
  task automatic write_byte(input logic [16:0] a, input logic [7:0] d, input bit byCs);
    addr = a; dataIn = d; oeN = 1; tick();
    if (byCs) weN = 0; else csN = 0;
    tick();
    if (byCs) csN = 0; else weN = 0;
    tick(); tick();
    if (byCs) csN = 1; else weN = 1;
    tick();
    csN = 1; weN = 1; tick();
  endtask

  // five edges; start on the second; address/data/oe may change before the end
  task automatic pulse_custom(input logic [16:0] a1, input logic [7:0] d1,
                              input logic [16:0] a2, input logic [7:0] d2,
                              input logic oeLevel, input bit dropOe);
    addr = a1; dataIn = d1; oeN = oeLevel; tick();
    csN = 0; weN = 0; tick();
    addr = a2; dataIn = d2;
    if (dropOe) oeN = 0;
    tick();
    csN = 1; weN = 1; tick();
    oeN = 1; tick();
  endtask

  task automatic wait_idle(output int n);
    n = 0;
    while (busy) begin tick(); n++; end
  endtask

  // ---------------- stimulus ----------------
  initial begin
    int n;
    rstN = 0; csN = 1; weN = 1; oeN = 1; addr = '0; dataIn = '0;
    repeat (4) tick();
    rstN = 1;
    tick();

    // R1: reset state
    chk("R1 busy after reset", busy, 0);
    chk("R2 outputs idle when deselected", dataOutEn, 0);
    read_chk("R1 read addr 0", 17'h00000, 8'h00);
    read_chk("R1 read top addr", 17'h1FFFF, 8'h00);

    // burst A on page 3, WE- and CS-controlled pulses
    write_byte(17'h00180, 8'h3C, 0);
    chk("R11 busy after first start", busy, 1);
    write_byte(17'h00185, 8'hA7, 1);
    write_byte(17'h00200, 8'h55, 0);   // other page: ignored
    write_byte(17'h001FF, 8'h81, 0);
    read_chk("R10 poll inverts bit7", 17'h001FF, 8'h01);
    read_chk("R10 other addr shows old array", 17'h00185, 8'h00);
    wait_idle(n);
    chk("R6 busy length after last start", 2 + n, L + P - 3);
    read_chk("R6 commit byte 0x180", 17'h00180, 8'h3C);
    read_chk("R6 commit byte 0x185", 17'h00185, 8'hA7);
    read_chk("R10 true data after commit", 17'h001FF, 8'h81);
    read_chk("R7 foreign page not written", 17'h00200, 8'h00);
    read_chk("R9 unloaded byte stays", 17'h00181, 8'h00);

    // burst B: capture points and retrigger
    pulse_custom(17'h00185, 8'h22, 17'h00186, 8'h11, 1'b1, 0);
    repeat (30) tick();
    write_byte(17'h001FE, 8'h7E, 1);
    read_chk("R10 poll with bit7 clear", 17'h001FE, 8'hFE);
    wait_idle(n);
    chk("R5 window restarted by second start", 1 + n, L + P - 3);
    read_chk("R4 address from start cycle", 17'h00185, 8'h11);
    read_chk("R4 later address unused", 17'h00186, 8'h00);
    read_chk("R5 retriggered byte committed", 17'h001FE, 8'h7E);
    read_chk("R9 byte 0x180 kept", 17'h00180, 8'h3C);
    read_chk("R9 byte 0x1FF kept", 17'h001FF, 8'h81);

    // burst C: writes during programming
    write_byte(17'h00300, 8'h42, 0);
    repeat (L) tick();
    write_byte(17'h00300, 8'h99, 0);
    write_byte(17'h00301, 8'h99, 1);
    wait_idle(n);
    chk("R8 busy not extended", L + 12 + n, L + P - 3);
    read_chk("R8 overwrite ignored", 17'h00300, 8'h42);
    read_chk("R8 new byte ignored", 17'h00301, 8'h00);

    // R3: output enable gating
    pulse_custom(17'h00280, 8'h5A, 17'h00280, 8'h5A, 1'b0, 0);
    chk("R3 oe low never starts", busy, 0);
    pulse_custom(17'h00280, 8'h5A, 17'h00280, 8'h5A, 1'b1, 1);
    chk("R3 accepted start raises busy", busy, 1);
    wait_idle(n);
    read_chk("R3 byte discarded when oe drops", 17'h00280, 8'h00);

    // aliasing of upper address bits onto the array
    read_chk("R2 aliased read", 17'h10180, 8'h3C);

    repeat (3) tick();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule